// File: doc/BRIEF.md
# Fully Associative Micro Translation Buffer

This block is a small first-level address translation cache placed in front of an instruction-fetch or a data-access port. It holds a set of recently used translations. Every lookup compares the presented virtual address and the current address space identifier against all slots at once, and in the same cycle it returns the physical address and the memory attribute byte of the matching slot. On a hit it checks the access against the domain access control word and the slot's permission code. A failed check raises an abort. That abort is a prefetch abort when the block is built for the instruction side and a data abort when it is built for the data side.

When no slot matches, the block raises a refill request that carries the virtual address. The walker outside the block later presents a complete entry on the refill port, and the block writes it into a round-robin victim slot. Software maintenance reaches the block as two strobes: one clears every slot, and the other clears only the non-global slots tagged with a given identifier. A slot can map a page of 4 KB, 64 KB, 1 MB or 16 MB. The compare ignores the address bits below the slot's page boundary, so slots of different sizes can sit side by side.

Top module: `micro_tlb`

## Requirements
- R1: Refills go to a victim slot. After reset the victim is slot 0, it advances by one on each refill and returns to 0 after the last slot (NUM_ENTRIES = 32). The 33rd refill after reset therefore replaces the first one.
- R2: Lookup is combinational. `lk_hit`, `lk_pa`, `lk_attr` and the abort outputs answer in the same cycle that `lk_valid`/`lk_va` are presented, and `lk_attr` is the attribute byte of the matching slot. While `lk_valid` is low, `lk_hit`, `miss_req` and both aborts are low.
- R3: Page size codes are 0 for 4 KB, 1 for 64 KB, 2 for 1 MB and 3 for 16 MB. These compare only VA[31:12], VA[31:16], VA[31:20] and VA[31:24] respectively. The physical address takes the slot's frame bits above that boundary and the VA bits below it, and any stored frame or page bits below the boundary are ignored.
- R4: A slot with `fill_global` set matches under any identifier. A non-global slot matches only when its stored identifier equals `cur_asid`.
- R5: When `lk_valid` is high and no slot matches, `miss_req` is high in that cycle and `miss_va` equals `lk_va`.
- R6: The domain of the hit slot selects the 2-bit field `dom_ctrl[2d+1:2d]`. Codes 00 and 10 always fault, code 11 never faults, and code 01 applies the permission check of R7.
- R7: The permission codes work as follows. Code 00 faults on every access. Code 01 faults on user accesses (`lk_priv` = 0). Code 10 faults only on user writes (`lk_write` = 1). Code 11 never faults.
- R8: A fault shows only together with a hit. It drives `prefetch_abort` when INSTR_SIDE = 1 and `data_abort` when INSTR_SIDE = 0, and the other abort output stays low.
- R9: A high `inv_all` clears every slot at the next clock edge. A refill presented in the same cycle is still written and remains valid.
- R10: A high `inv_asid_en` clears, at the next edge, only the non-global slots whose identifier equals `inv_asid`. Global slots and slots with other identifiers stay valid.
- R11: Synchronous active-low reset leaves every slot invalid, so every valid lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_priv | input | 1 | Access is privileged |
| cur_asid | input | 8 | Current address space identifier |
| dom_ctrl | input | 32 | Sixteen 2-bit domain access codes |
| lk_hit | output | 1 | A slot matched |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 8 | Attribute byte of the matching slot |
| prefetch_abort | output | 1 | Fault on the instruction side |
| data_abort | output | 1 | Fault on the data side |
| miss_req | output | 1 | Refill request |
| miss_va | output | 32 | Address that missed |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | 20 | Refill virtual page bits VA[31:12] |
| fill_ppn | input | 20 | Refill physical frame bits PA[31:12] |
| fill_size | input | 2 | Refill page size code |
| fill_global | input | 1 | Refill entry is global |
| fill_asid | input | 8 | Refill identifier |
| fill_domain | input | 4 | Refill domain number |
| fill_ap | input | 2 | Refill permission code |
| fill_attr | input | 8 | Refill attribute byte |
| inv_all | input | 1 | Clear every slot |
| inv_asid_en | input | 1 | Clear non-global slots of `inv_asid` |
| inv_asid | input | 8 | Identifier to clear |

## Verification
The lookup is combinational, so a corrupted slot tag, size code or identifier shows up as a wrong hit or miss, or a wrong physical address, on the first lookup that touches that slot. A wrong domain or permission decode shows the same way on the abort pins. Faults in the victim pointer or the invalidation logic stay hidden until a later lookup. They appear as a surviving slot that should have been cleared, or as a lost slot that should have survived. The bench therefore probes specific slots after each refill sequence and after each invalidation strobe.

// File: rtl/mtlb_pkg.sv
// Package: shared widths, codes and the slot record for the micro translation buffer.
// Assumes 32-bit virtual and physical addresses and a 4 KB smallest page.
package mtlb_pkg;
    parameter int VA_W       = 32;
    parameter int PAGE_SHIFT = 12;
    parameter int VPN_W      = VA_W - PAGE_SHIFT;
    parameter int ASID_W     = 8;
    parameter int NUM_DOM    = 16;
    parameter int DOM_W      = $clog2(NUM_DOM);
    parameter int ATTR_W     = 8;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        DOM_DENY   = 2'b00,
        DOM_CLIENT = 2'b01,
        DOM_RSVD   = 2'b10,
        DOM_MGR    = 2'b11
    } dom_code_e;

    typedef enum logic [1:0] {
        AP_NONE    = 2'b00,
        AP_PRIV    = 2'b01,
        AP_USER_RO = 2'b10,
        AP_FULL    = 2'b11
    } ap_code_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        pg_size_e          size;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [DOM_W-1:0]  dom;
        ap_code_e          ap;
        logic [ATTR_W-1:0] attr;
    } tlb_entry_t;

    // Mask of page-number bits that take part in the compare for a page size.
    function automatic logic [VPN_W-1:0] size_mask(input pg_size_e s);
        logic [VPN_W-1:0] m;
        case (s)
            PG_4K:   m = '1;
            PG_64K:  m = {{(VPN_W-4){1'b1}}, 4'h0};
            PG_1M:   m = {{(VPN_W-8){1'b1}}, 8'h00};
            default: m = {{(VPN_W-12){1'b1}}, 12'h000};
        endcase
        return m;
    endfunction
endpackage

// File: rtl/mtlb_victim.sv
// Module: round-robin victim pointer for refills.
// Assumes one refill per cycle at most; the pointer wraps after the last slot.
module mtlb_victim #(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    // Advance the pointer on every refill, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (adv)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/mtlb_store.sv
// Module: slot storage with valid bits, refill write and both invalidations.
// Assumes the refill write outranks an invalidation that hits the same slot.
module mtlb_store
    import mtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_data,
    input  logic                   inv_all,
    input  logic                   inv_asid_en,
    input  logic [ASID_W-1:0]      inv_asid,
    output tlb_entry_t             ent_q [NUM_ENTRIES],
    output logic [NUM_ENTRIES-1:0] vld_q
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        logic sel;
        logic asid_kill;

        // Decode whether this slot is written or hit by the identifier flush.
        always_comb begin
            sel       = wr_en && (wr_idx == IDX_W'(i));
            asid_kill = inv_asid_en && !ent_q[i].glob && (ent_q[i].asid == inv_asid);
        end

        // Hold the slot contents; load them on a refill to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[i] <= '0;
            else if (sel)
                ent_q[i] <= wr_data;
        end

        // Track validity: refill sets, either invalidation clears.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld_q[i] <= 1'b0;
            else if (sel)
                vld_q[i] <= 1'b1;
            else if (inv_all || asid_kill)
                vld_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/mtlb_match.sv
// Module: parallel tag compare across all slots with lowest-index selection.
// Assumes the caller gives page-number bits only; offset handling is outside.
module mtlb_match
    import mtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32
) (
    input  tlb_entry_t             ent [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] vld,
    input  logic [VPN_W-1:0]       va_vpn,
    input  logic [ASID_W-1:0]      cur_asid,
    output logic                   any_hit,
    output tlb_entry_t             sel_ent
);
    logic [NUM_ENTRIES-1:0] match;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        logic [VPN_W-1:0] m;
        logic             tag_ok;
        logic             asid_ok;

        // Compare the masked page number and the identifier of one slot.
        always_comb begin
            m        = size_mask(ent[i].size);
            tag_ok   = ((ent[i].vpn ^ va_vpn) & m) == '0;
            asid_ok  = ent[i].glob || (ent[i].asid == cur_asid);
            match[i] = vld[i] && tag_ok && asid_ok;
        end
    end

    // Pick the lowest-numbered matching slot.
    always_comb begin
        any_hit = 1'b0;
        sel_ent = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit = 1'b1;
                sel_ent = ent[i];
            end
        end
    end
endmodule

// File: rtl/mtlb_perm.sv
// Module: domain and permission check for the selected slot.
// Assumes a 2-bit code per domain packed low-domain-first in dom_ctrl.
module mtlb_perm
    import mtlb_pkg::*;
(
    input  logic [2*NUM_DOM-1:0] dom_ctrl,
    input  logic [DOM_W-1:0]     dom,
    input  ap_code_e             ap,
    input  logic                 priv,
    input  logic                 write,
    output logic                 fault
);
    dom_code_e dc;
    logic      ap_fault;

    // Extract this slot's domain code.
    always_comb dc = dom_code_e'(dom_ctrl[2*dom +: 2]);

    // Decode the permission code against privilege and direction.
    always_comb begin
        case (ap)
            AP_NONE:    ap_fault = 1'b1;
            AP_PRIV:    ap_fault = !priv;
            AP_USER_RO: ap_fault = !priv && write;
            default:    ap_fault = 1'b0;
        endcase
    end

    // Combine domain policy with the permission result.
    always_comb begin
        case (dc)
            DOM_MGR:    fault = 1'b0;
            DOM_CLIENT: fault = ap_fault;
            default:    fault = 1'b1;
        endcase
    end
endmodule

// File: rtl/micro_tlb.sv
// Module: fully associative micro translation buffer, one per access side.
// Lookup, physical address build and fault decision are combinational;
// refill and invalidation take effect at the next clock edge.
// Assumes the walker answers a miss with a refill some cycles later.
module micro_tlb
    import mtlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    parameter bit INSTR_SIDE  = 1'b0,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VA_W-1:0]      lk_va,
    input  logic                 lk_write,
    input  logic                 lk_priv,
    input  logic [ASID_W-1:0]    cur_asid,
    input  logic [2*NUM_DOM-1:0] dom_ctrl,
    output logic                 lk_hit,
    output logic [VA_W-1:0]      lk_pa,
    output logic [ATTR_W-1:0]    lk_attr,
    output logic                 prefetch_abort,
    output logic                 data_abort,
    output logic                 miss_req,
    output logic [VA_W-1:0]      miss_va,
    input  logic                 fill_valid,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [VPN_W-1:0]     fill_ppn,
    input  logic [1:0]           fill_size,
    input  logic                 fill_global,
    input  logic [ASID_W-1:0]    fill_asid,
    input  logic [DOM_W-1:0]     fill_domain,
    input  logic [1:0]           fill_ap,
    input  logic [ATTR_W-1:0]    fill_attr,
    input  logic                 inv_all,
    input  logic                 inv_asid_en,
    input  logic [ASID_W-1:0]    inv_asid
);
    tlb_entry_t             ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] vld_q;
    tlb_entry_t             wr_data;
    tlb_entry_t             sel_ent;
    logic [IDX_W-1:0]       victim;
    logic                   any_hit;
    logic                   fault;
    logic [VPN_W-1:0]       m;
    logic                   abort_now;

    // Pack the refill port into a slot record.
    always_comb begin
        wr_data.vpn  = fill_vpn;
        wr_data.ppn  = fill_ppn;
        wr_data.size = pg_size_e'(fill_size);
        wr_data.glob = fill_global;
        wr_data.asid = fill_asid;
        wr_data.dom  = fill_domain;
        wr_data.ap   = ap_code_e'(fill_ap);
        wr_data.attr = fill_attr;
    end

    mtlb_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fill_valid),
        .idx   (victim)
    );

    mtlb_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (fill_valid),
        .wr_idx      (victim),
        .wr_data     (wr_data),
        .inv_all     (inv_all),
        .inv_asid_en (inv_asid_en),
        .inv_asid    (inv_asid),
        .ent_q       (ent_q),
        .vld_q       (vld_q)
    );

    mtlb_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_match (
        .ent      (ent_q),
        .vld      (vld_q),
        .va_vpn   (lk_va[VA_W-1:PAGE_SHIFT]),
        .cur_asid (cur_asid),
        .any_hit  (any_hit),
        .sel_ent  (sel_ent)
    );

    mtlb_perm u_perm (
        .dom_ctrl (dom_ctrl),
        .dom      (sel_ent.dom),
        .ap       (sel_ent.ap),
        .priv     (lk_priv),
        .write    (lk_write),
        .fault    (fault)
    );

    // Build the physical address from frame bits above the page boundary.
    always_comb begin
        m       = size_mask(sel_ent.size);
        lk_hit  = lk_valid && any_hit;
        lk_pa   = {(sel_ent.ppn & m) | (lk_va[VA_W-1:PAGE_SHIFT] & ~m),
                   lk_va[PAGE_SHIFT-1:0]};
        lk_attr = sel_ent.attr;
    end

    // Raise the refill request on a valid lookup that found nothing.
    always_comb begin
        miss_req = lk_valid && !any_hit;
        miss_va  = lk_va;
    end

    // Route a fault to the abort of the side this instance serves.
    always_comb abort_now = lk_hit && fault;

    if (INSTR_SIDE) begin : g_ifetch
        // Instruction side: only prefetch aborts.
        always_comb begin
            prefetch_abort = abort_now;
            data_abort     = 1'b0;
        end
    end else begin : g_data
        // Data side: only data aborts.
        always_comb begin
            prefetch_abort = 1'b0;
            data_abort     = abort_now;
        end
    end
endmodule

// File: rtl/micro_tlb_checker.sv
// Module: port-level properties of the micro translation buffer, bound to it.
module micro_tlb_checker
    import mtlb_pkg::*;
#(
    parameter bit INSTR_SIDE = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_va,
    input logic            lk_hit,
    input logic [VA_W-1:0] lk_pa,
    input logic            prefetch_abort,
    input logic            data_abort,
    input logic            miss_req,
    input logic [VA_W-1:0] miss_va,
    input logic            fill_valid,
    input logic            inv_all
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !miss_req && !prefetch_abort && !data_abort));

    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[PAGE_SHIFT-1:0] == lk_va[PAGE_SHIFT-1:0]));

    assert_miss_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> (!lk_hit && lk_valid && miss_va == lk_va));

    assert_abort_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prefetch_abort || data_abort) |-> lk_hit);

    assert_abort_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
        INSTR_SIDE ? !data_abort : !prefetch_abort);

    assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_valid) |=> !lk_hit);
endmodule

bind micro_tlb micro_tlb_checker #(.INSTR_SIDE(INSTR_SIDE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_valid       (lk_valid),
    .lk_va          (lk_va),
    .lk_hit         (lk_hit),
    .lk_pa          (lk_pa),
    .prefetch_abort (prefetch_abort),
    .data_abort     (data_abort),
    .miss_req       (miss_req),
    .miss_va        (miss_va),
    .fill_valid     (fill_valid),
    .inv_all        (inv_all)
);

// File: tb/micro_tlb_bench.sv
`timescale 1ns/1ps
module micro_tlb_bench;
    import mtlb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 lk_valid = 1'b0;
    logic [VA_W-1:0]      lk_va = '0;
    logic                 lk_write = 1'b0;
    logic                 lk_priv = 1'b0;
    logic [ASID_W-1:0]    cur_asid = '0;
    logic [2*NUM_DOM-1:0] dom_ctrl = '0;
    logic                 fill_valid = 1'b0;
    logic [VPN_W-1:0]     fill_vpn = '0;
    logic [VPN_W-1:0]     fill_ppn = '0;
    logic [1:0]           fill_size = '0;
    logic                 fill_global = 1'b0;
    logic [ASID_W-1:0]    fill_asid = '0;
    logic [DOM_W-1:0]     fill_domain = '0;
    logic [1:0]           fill_ap = '0;
    logic [ATTR_W-1:0]    fill_attr = '0;
    logic                 inv_all = 1'b0;
    logic                 inv_asid_en = 1'b0;
    logic [ASID_W-1:0]    inv_asid = '0;

    logic d_hit, d_pab, d_dab, d_miss, i_hit, i_pab, i_dab, i_miss;
    logic [VA_W-1:0] d_pa, d_mva, i_pa, i_mva;
    logic [ATTR_W-1:0] d_attr, i_attr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    micro_tlb #(.NUM_ENTRIES(32), .INSTR_SIDE(1'b0)) u_micro_tlb (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_write(lk_write), .lk_priv(lk_priv), .cur_asid(cur_asid),
        .dom_ctrl(dom_ctrl), .lk_hit(d_hit), .lk_pa(d_pa), .lk_attr(d_attr),
        .prefetch_abort(d_pab), .data_abort(d_dab), .miss_req(d_miss),
        .miss_va(d_mva), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_global(fill_global),
        .fill_asid(fill_asid), .fill_domain(fill_domain), .fill_ap(fill_ap),
        .fill_attr(fill_attr), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
        .inv_asid(inv_asid)
    );

    micro_tlb #(.NUM_ENTRIES(32), .INSTR_SIDE(1'b1)) u_micro_tlb_ifetch (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_write(lk_write), .lk_priv(lk_priv), .cur_asid(cur_asid),
        .dom_ctrl(dom_ctrl), .lk_hit(i_hit), .lk_pa(i_pa), .lk_attr(i_attr),
        .prefetch_abort(i_pab), .data_abort(i_dab), .miss_req(i_miss),
        .miss_va(i_mva), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_global(fill_global),
        .fill_asid(fill_asid), .fill_domain(fill_domain), .fill_ap(fill_ap),
        .fill_attr(fill_attr), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
        .inv_asid(inv_asid)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        v;
        logic [31:0] va;
        logic        wr;
        logic        priv;
        logic [7:0]  asid;
        logic [31:0] dc;
        logic        ehit;
        logic [31:0] epa;
        logic [7:0]  eattr;
        logic        eab;
    } vec_t;

    localparam int NV = 17;
    // Lookups against four slots: 4K asid5 dom0 ap11, 64K global dom1 ap01,
    // 1M global dom2 ap10, 16M asid7 dom3 ap00.
    localparam vec_t VECS [NV] = '{
        '{8'd4, 1'b1, 32'h00012ABC, 1'b0, 1'b0, 8'd5, 32'h55, 1'b1, 32'h80034ABC, 8'h11, 1'b0}, // R4 own asid
        '{8'd4, 1'b1, 32'h00012ABC, 1'b0, 1'b0, 8'd6, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}, // R4 other asid
        '{8'd7, 1'b1, 32'h00457123, 1'b0, 1'b0, 8'd9, 32'h55, 1'b1, 32'h9ABC7123, 8'h22, 1'b1}, // R7 priv-only, user
        '{8'd7, 1'b1, 32'h00457123, 1'b1, 1'b1, 8'd9, 32'h55, 1'b1, 32'h9ABC7123, 8'h22, 1'b0}, // R7 priv write
        '{8'd3, 1'b1, 32'h12345678, 1'b0, 1'b0, 8'd9, 32'h55, 1'b1, 32'h45645678, 8'h33, 1'b0}, // R3 1M
        '{8'd7, 1'b1, 32'h12345678, 1'b1, 1'b0, 8'd9, 32'h55, 1'b1, 32'h45645678, 8'h33, 1'b1}, // R7 user write ro
        '{8'd7, 1'b1, 32'h12345678, 1'b1, 1'b1, 8'd9, 32'h55, 1'b1, 32'h45645678, 8'h33, 1'b0}, // R7 priv write ro
        '{8'd7, 1'b1, 32'hAB123456, 1'b0, 1'b1, 8'd7, 32'h55, 1'b1, 32'hCD123456, 8'h44, 1'b1}, // R7 no-access code
        '{8'd4, 1'b1, 32'hAB123456, 1'b0, 1'b1, 8'd5, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}, // R4 16M wrong asid
        '{8'd6, 1'b1, 32'hAB123456, 1'b0, 1'b1, 8'd7, 32'hD5, 1'b1, 32'hCD123456, 8'h44, 1'b0}, // R6 manager
        '{8'd6, 1'b1, 32'h00012ABC, 1'b0, 1'b1, 8'd5, 32'h54, 1'b1, 32'h80034ABC, 8'h11, 1'b1}, // R6 domain 00
        '{8'd6, 1'b1, 32'h00012ABC, 1'b0, 1'b1, 8'd5, 32'h56, 1'b1, 32'h80034ABC, 8'h11, 1'b1}, // R6 domain 10
        '{8'd3, 1'b1, 32'h00460000, 1'b0, 1'b0, 8'd9, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}, // R3 above 64K
        '{8'd3, 1'b1, 32'h0044FFFF, 1'b0, 1'b0, 8'd9, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}, // R3 below 64K
        '{8'd3, 1'b1, 32'h12400000, 1'b0, 1'b0, 8'd9, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}, // R3 next 1M
        '{8'd3, 1'b1, 32'h00450000, 1'b0, 1'b0, 8'd9, 32'h55, 1'b1, 32'h9ABC0000, 8'h22, 1'b1}, // R3 64K base
        '{8'd2, 1'b0, 32'h00012ABC, 1'b0, 1'b0, 8'd5, 32'h55, 1'b0, 32'h0,        8'h00, 1'b0}  // R2 idle
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [1:0] sz, input logic g, input logic [7:0] as,
                        input logic [3:0] dm, input logic [1:0] ap,
                        input logic [7:0] at, input logic flush);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_size = sz;
        fill_global = g; fill_asid = as; fill_domain = dm; fill_ap = ap;
        fill_attr = at; inv_all = flush;
        @(negedge clk);
        fill_valid = 1'b0; inv_all = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic wr, input logic pv,
                        input logic [7:0] as, input logic [31:0] dc);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va; lk_write = wr; lk_priv = pv;
        cur_asid = as; dom_ctrl = dc;
        #1;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: nothing valid after reset
        look(32'h00012ABC, 1'b0, 1'b1, 8'd5, 32'h55);
        chk("R11", "hit after reset", {63'd0, d_hit}, 64'd0);
        chk("R11", "miss after reset", {63'd0, d_miss}, 64'd1);
        lk_valid = 1'b0;

        fill(20'h00012, 20'h80034, 2'd0, 1'b0, 8'd5, 4'd0, 2'b11, 8'h11, 1'b0);
        fill(20'h0045A, 20'h9ABC3, 2'd1, 1'b1, 8'd0, 4'd1, 2'b01, 8'h22, 1'b0);
        fill(20'h123AB, 20'h456FF, 2'd2, 1'b1, 8'd0, 4'd2, 2'b10, 8'h33, 1'b0);
        fill(20'hAB0FF, 20'hCD0EE, 2'd3, 1'b0, 8'd7, 4'd3, 2'b00, 8'h44, 1'b0);

        for (int k = 0; k < NV; k++) begin
            look(VECS[k].va, VECS[k].wr, VECS[k].priv, VECS[k].asid, VECS[k].dc);
            lk_valid = VECS[k].v;
            #0.5;
            tag = $sformatf("R%0d", VECS[k].req);
            chk(tag, $sformatf("vec%0d hit", k), {63'd0, d_hit}, {63'd0, VECS[k].ehit});
            chk(tag, $sformatf("vec%0d ifetch hit", k), {63'd0, i_hit}, {63'd0, VECS[k].ehit});
            if (VECS[k].ehit) begin
                chk(tag, $sformatf("vec%0d pa", k), {32'd0, d_pa}, {32'd0, VECS[k].epa});
                chk("R2", $sformatf("vec%0d attr", k), {56'd0, d_attr}, {56'd0, VECS[k].eattr});
            end
            chk("R5", $sformatf("vec%0d miss", k), {63'd0, d_miss},
                {63'd0, VECS[k].v & ~VECS[k].ehit});
            if (VECS[k].v && !VECS[k].ehit)
                chk("R5", $sformatf("vec%0d miss va", k), {32'd0, d_mva}, {32'd0, VECS[k].va});
            chk("R8", $sformatf("vec%0d data abort", k), {62'd0, d_dab, d_pab}, {62'd0, VECS[k].eab, 1'b0});
            chk("R8", $sformatf("vec%0d prefetch abort", k), {62'd0, i_dab, i_pab}, {62'd0, 1'b0, VECS[k].eab});
        end
        lk_valid = 1'b0;

        // R10: flush identifier 5 only
        @(negedge clk);
        inv_asid_en = 1'b1; inv_asid = 8'd5;
        @(negedge clk);
        inv_asid_en = 1'b0;
        look(32'h00012ABC, 1'b0, 1'b1, 8'd5, 32'h55);
        chk("R10", "asid5 slot cleared", {63'd0, d_hit}, 64'd0);
        look(32'hAB123456, 1'b0, 1'b1, 8'd7, 32'hD5);
        chk("R10", "asid7 slot kept", {63'd0, d_hit}, 64'd1);
        look(32'h00457123, 1'b0, 1'b1, 8'd5, 32'h55);
        chk("R10", "global slot kept", {63'd0, d_hit}, 64'd1);
        lk_valid = 1'b0;

        // R9: flush everything while a refill lands
        fill(20'h00777, 20'h11111, 2'd0, 1'b1, 8'd0, 4'd0, 2'b11, 8'h55, 1'b1);
        look(32'h00777ABC, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R9", "refill survives flush", {63'd0, d_hit}, 64'd1);
        chk("R9", "refill pa", {32'd0, d_pa}, {32'd0, 32'h11111ABC});
        look(32'h00457123, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R9", "global slot flushed", {63'd0, d_hit}, 64'd0);
        look(32'hAB123456, 1'b0, 1'b1, 8'd7, 32'h55);
        chk("R9", "asid slot flushed", {63'd0, d_hit}, 64'd0);
        lk_valid = 1'b0;

        // R1: victim order and wrap after reset
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int n = 0; n < 33; n++)
            fill(20'h20000 + 20'(n), 20'h30000 + 20'(n), 2'd0, 1'b1, 8'd0, 4'd0, 2'b11, 8'h66, 1'b0);
        look(32'h20000000, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R1", "first refill replaced", {63'd0, d_hit}, 64'd0);
        look(32'h20001010, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R1", "second refill kept", {32'd0, d_pa}, {32'd0, 32'h30001010});
        chk("R1", "second refill hit", {63'd0, d_hit}, 64'd1);
        look(32'h2001F000, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R1", "32nd refill hit", {63'd0, d_hit}, 64'd1);
        look(32'h20020004, 1'b0, 1'b1, 8'd0, 32'h55);
        chk("R1", "33rd refill pa", {32'd0, d_pa}, {32'd0, 32'h30020004});
        lk_valid = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule